// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the current time and date as seven packed-BCD registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle `tick_1hz` strobe from an external prescaler advances the seconds. Carries ripple up through minutes, hours and the calendar fields within the same clock edge. Month lengths and leap years are handled without help from the host.

A host loads any field with a single-cycle write. It selects the field on `wr_sel` and presents the value on `wr_data`. The stored value appears on the outputs one clock later.

The hours register can count in 24-hour form or in 12-hour form with a PM flag. The top bit of the seconds register stops all counting while it is set. Every pin is a plain control or status signal: nothing streams in or out, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 0x00 with the halt bit clear, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: When a tick arrives and halt is clear, seconds (bits 6:0, BCD) advance by one. 59 wraps to 00 and advances minutes. Minutes 59 wrap to 00 and advance the hours.
- R3: While seconds bit 7 (halt) is 1, ticks change no register.
- R4: With hours bit 6 = 0 (24-hour mode), bits 5:0 count 00 to 23 in BCD. 23 wraps to 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour mode), bit 5 is PM and bits 4:0 count 12, 01 … 11 in BCD. PM toggles on the step from 11 to 12. The day advances on the step from 11 PM to 12 AM.
- R6: Date rolls to 01 and advances the month after day 30 in months 04, 06, 09 and 11, after day 28 in February of a non-leap year, and after day 31 in every other month.
- R7: February has 29 days when the BCD year is divisible by 4, and year 00 counts as such a year.
- R8: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00.
- R9: Weekday counts 1 to 7, wraps to 1, and advances exactly when the date advances.
- R10: A write with `wr_en` = 1 loads the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year) on the next edge. `wr_sel` = 7 changes nothing. A write takes priority over a tick in the same cycle, and the written field passes no carry onward in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle advance strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Value to write (BCD plus control bits) |
| seconds_o | output | 8 | Halt bit 7, BCD seconds in bits 6:0 |
| minutes_o | output | 8 | BCD minutes |
| hours_o | output | 8 | Mode bit 6, PM/tens bit 5, BCD hours |
| weekday_o | output | 8 | Weekday 1..7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year 00..99 |

## Verification
The bench sweeps the last days of every month across years 00 to 04, 12, 96 and 99. A wrong month-length table or leap test would show up as a 31st of April, a missing 29 February or a year stuck at 99. A full 24-step walk in 12-hour mode covers the 11→12 PM flip and the 12→01 wrap. A design that toggled PM at 12→01 would advance the day at noon. Ticks that collide with writes check two faults: a write lost to the increment, or a carry leaking out of a field that was just written. Ticks under halt would expose a clock that drifts while stopped.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  typedef enum logic [2:0] {
    FLD_SEC = 3'd0, FLD_MIN = 3'd1, FLD_HOUR = 3'd2, FLD_DOW = 3'd3,
    FLD_DATE = 3'd4, FLD_MONTH = 3'd5, FLD_YEAR = 3'd6, FLD_NONE = 3'd7
  } fld_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    logic r;
    if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
    logic [5:0] r;
    case (m)
      5'h02:                      r = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
`timescale 1ns/1ps
module rtc_bcd_wrap #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   MINV = '0,
  parameter logic [W-1:0]   MAXV = W'(8'h59),
  parameter logic [W-1:0]   RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         carry
);
  import rtc_cal_pkg::*;
  localparam int PAD = 8 - W;

  logic [7:0] wide_next;
  assign wide_next = bcd_inc({{PAD{1'b0}}, value});
  assign carry = adv && !wr && (value == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              value <= RSTV;
    else if (wr)             value <= wdata;
    else if (adv) begin
      if (value == MAXV)     value <= MINV;
      else                   value <= wide_next[W-1:0];
    end
  end

  // R2 (also R8, R9): the top value wraps to the bottom one on an advance
  a_r2_wrap_to_min: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && value == MAXV |=> value == MINV);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> value == $past(wdata));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !wr |=> $stable(value));
endmodule

// File: rtl/rtc_hour_unit.sv
`timescale 1ns/1ps
module rtc_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr,
  input  logic [6:0] wdata,
  output logic [6:0] value,
  output logic       day_carry
);
  import rtc_cal_pkg::*;

  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [5:0] h24;
  logic [7:0] inc12, inc24;
  logic [6:0] nxt;
  logic       roll;

  assign mode12 = value[6];
  assign pm     = value[5];
  assign h12    = value[4:0];
  assign h24    = value[5:0];
  assign inc12  = bcd_inc({3'b000, h12});
  assign inc24  = bcd_inc({2'b00, h24});

  always_comb begin
    nxt  = value;
    roll = 1'b0;
    if (mode12) begin
      if (h12 == 5'h12)      nxt = {1'b1, pm, 5'h01};
      else if (h12 == 5'h11) begin
        nxt  = {1'b1, ~pm, 5'h12};
        roll = pm;
      end else               nxt = {1'b1, pm, inc12[4:0]};
    end else begin
      if (h24 == 6'h23) begin
        nxt  = 7'h00;
        roll = 1'b1;
      end else               nxt = {1'b0, inc24[5:0]};
    end
  end

  assign day_carry = adv && !wr && roll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= 7'h00;
    else if (wr)  value <= wdata;
    else if (adv) value <= nxt;
  end

  a_r5_pm_flips_at_eleven: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && mode12 && h12 == 5'h11 |=> value[5] != $past(value[5]) && value[4:0] == 5'h12);
  a_r5_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && mode12 && h12 == 5'h12 |=> value[4:0] == 5'h01 && $stable(value[6:5]));
  a_r4_midnight_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && !mode12 && h24 == 6'h23 |=> value == 7'h00);
endmodule

// File: rtl/rtc_date_unit.sv
`timescale 1ns/1ps
module rtc_date_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr,
  input  logic [5:0] wdata,
  input  logic [5:0] last_day,
  output logic [5:0] value,
  output logic       carry
);
  import rtc_cal_pkg::*;

  logic [7:0] inc;
  logic       at_end;
  assign inc    = bcd_inc({2'b00, value});
  assign at_end = (value == last_day);
  assign carry  = adv && !wr && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= 6'h01;
    else if (wr)  value <= wdata;
    else if (adv) value <= at_end ? 6'h01 : inc[5:0];
  end

  // R6: the month's last day is followed by day 01
  a_r6_last_day_rolls: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && at_end |=> value == 6'h01);
  a_r6_mid_month_steps: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr && !at_end |=> value != 6'h01);
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] seconds_o,
  output logic [7:0] minutes_o,
  output logic [7:0] hours_o,
  output logic [7:0] weekday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  import rtc_cal_pkg::*;

  logic       halt_q;
  logic       w_sec, w_min, w_hour, w_dow, w_date, w_mon, w_year;
  logic       adv_sec, c_sec, c_min, c_day, c_date, c_mon, c_year, c_dow;
  logic [6:0] sec_v, min_v, hour_v;
  logic [2:0] dow_v;
  logic [5:0] date_v, last_v;
  logic [4:0] mon_v;
  logic [7:0] year_v;

  assign w_sec  = wr_en && (wr_sel == FLD_SEC);
  assign w_min  = wr_en && (wr_sel == FLD_MIN);
  assign w_hour = wr_en && (wr_sel == FLD_HOUR);
  assign w_dow  = wr_en && (wr_sel == FLD_DOW);
  assign w_date = wr_en && (wr_sel == FLD_DATE);
  assign w_mon  = wr_en && (wr_sel == FLD_MONTH);
  assign w_year = wr_en && (wr_sel == FLD_YEAR);

  assign adv_sec = tick_1hz && !halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     halt_q <= 1'b0;
    else if (w_sec) halt_q <= wr_data[7];
  end

  rtc_bcd_wrap #(.W(7), .MINV(7'h00), .MAXV(7'h59), .RSTV(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(adv_sec), .wr(w_sec), .wdata(wr_data[6:0]),
    .value(sec_v), .carry(c_sec));

  rtc_bcd_wrap #(.W(7), .MINV(7'h00), .MAXV(7'h59), .RSTV(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .adv(c_sec), .wr(w_min), .wdata(wr_data[6:0]),
    .value(min_v), .carry(c_min));

  rtc_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .adv(c_min), .wr(w_hour), .wdata(wr_data[6:0]),
    .value(hour_v), .day_carry(c_day));

  rtc_bcd_wrap #(.W(3), .MINV(3'd1), .MAXV(3'd7), .RSTV(3'd1)) u_dow (
    .clk(clk), .rst_n(rst_n), .adv(c_day), .wr(w_dow), .wdata(wr_data[2:0]),
    .value(dow_v), .carry(c_dow));

  assign last_v = month_last(mon_v, is_leap(year_v));

  rtc_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .adv(c_day), .wr(w_date), .wdata(wr_data[5:0]),
    .last_day(last_v), .value(date_v), .carry(c_date));

  rtc_bcd_wrap #(.W(5), .MINV(5'h01), .MAXV(5'h12), .RSTV(5'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .adv(c_date), .wr(w_mon), .wdata(wr_data[4:0]),
    .value(mon_v), .carry(c_mon));

  rtc_bcd_wrap #(.W(8), .MINV(8'h00), .MAXV(8'h99), .RSTV(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .adv(c_mon), .wr(w_year), .wdata(wr_data),
    .value(year_v), .carry(c_year));

  assign seconds_o = {halt_q, sec_v};
  assign minutes_o = {1'b0, min_v};
  assign hours_o   = {1'b0, hour_v};
  assign weekday_o = {5'd0, dow_v};
  assign date_o    = {2'b00, date_v};
  assign month_o   = {3'b000, mon_v};
  assign year_o    = year_v;

  a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && halt_q && !wr_en |=> $stable(seconds_o) && $stable(minutes_o)
      && $stable(hours_o) && $stable(date_o) && $stable(year_o));
  a_r9_dow_with_date: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && $past(date_o) != date_o |-> $past(weekday_o) != weekday_o);
  a_r10_sel7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == FLD_NONE && !tick_1hz |=> $stable(seconds_o) && $stable(minutes_o)
      && $stable(hours_o) && $stable(weekday_o) && $stable(date_o) && $stable(month_o)
      && $stable(year_o));
  a_r10_carry_cut: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && w_sec |=> $stable(minutes_o));
endmodule

// File: tb/rtc_calendar_core_test.sv
`timescale 1ns/1ps
module rtc_calendar_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] seconds_o, minutes_o, hours_o, weekday_o, date_o, month_o, year_o;

  int n_cmp = 0;
  int n_bad = 0;

  int m_sec = 0, m_min = 0, m_hr = 0, m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0;
  bit m_halt = 0, m_12 = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seconds_o(seconds_o), .minutes_o(minutes_o), .hours_o(hours_o),
    .weekday_o(weekday_o), .date_o(date_o), .month_o(month_o), .year_o(year_o));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_hour();
    int h;
    if (!m_12) return bcd(m_hr);
    h = m_hr % 12;
    if (h == 0) h = 12;
    return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | bcd(h);
  endfunction

  task automatic chk(input string req, input string fld, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, fld, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "seconds", seconds_o, {m_halt, bcd(m_sec)[6:0]});
    chk(req, "minutes", minutes_o, bcd(m_min));
    chk(req, "hours",   hours_o,   exp_hour());
    chk(req, "weekday", weekday_o, bcd(m_dow));
    chk(req, "date",    date_o,    bcd(m_date));
    chk(req, "month",   month_o,   bcd(m_mon));
    chk(req, "year",    year_o,    bcd(m_yr));
  endtask

  task automatic cyc(input bit tk, input bit we, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    tick_1hz = tk; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    tick_1hz = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 8'd0;
  endtask

  task automatic model_tick();
    if (m_halt) return;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow % 7) + 1;
          m_date++;
          if (m_date > mdays(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr = (m_yr + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic tick1();
    cyc(1'b1, 1'b0, 3'd0, 8'h00);
    model_tick();
  endtask

  task automatic load_hms();
    cyc(1'b0, 1'b1, 3'd0, {m_halt, bcd(m_sec)[6:0]});
    cyc(1'b0, 1'b1, 3'd1, bcd(m_min));
    cyc(1'b0, 1'b1, 3'd2, exp_hour());
  endtask

  task automatic load_all();
    load_hms();
    cyc(1'b0, 1'b1, 3'd3, bcd(m_dow));
    cyc(1'b0, 1'b1, 3'd4, bcd(m_date));
    cyc(1'b0, 1'b1, 3'd5, bcd(m_mon));
    cyc(1'b0, 1'b1, 3'd6, bcd(m_yr));
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int years[8] = '{0, 1, 2, 3, 4, 12, 96, 99};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #5;
    chk_all("R1");

    // R2 / R4: continuous run across minute and hour boundaries
    for (int i = 0; i < 3700; i++) begin
      tick1();
      chk_all("R2/R4");
    end

    // R6 / R7 / R8 / R9: end-of-month sweep, one day per tick
    foreach (years[yi]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        m_12 = 0; m_halt = 0;
        m_yr = years[yi]; m_mon = mo; m_date = 26; m_dow = (mo % 7) + 1;
        m_hr = 23; m_min = 59; m_sec = 59;
        load_all();
        for (int d = 0; d < 6; d++) begin
          tick1();
          chk_all("R6/R7/R8/R9");
          m_hr = 23; m_min = 59; m_sec = 59;
          load_hms();
        end
      end
    end

    // R5: walk every hour of a day in 12-hour mode, then past midnight
    m_12 = 1; m_hr = 22; m_min = 59; m_sec = 59; m_date = 10; m_mon = 3; m_yr = 5; m_dow = 6;
    load_all();
    for (int i = 0; i < 28; i++) begin
      tick1();
      chk_all("R5");
      m_min = 59; m_sec = 59;
      load_hms();
    end

    // R3: halt freezes everything
    m_12 = 0; m_hr = 23; m_min = 59; m_sec = 59; m_halt = 1;
    load_hms();
    chk_all("R3");
    for (int i = 0; i < 5; i++) begin
      tick1();
      chk_all("R3");
    end
    m_halt = 0;
    load_hms();
    tick1();
    chk_all("R3");

    // R10: collisions and the unused selector
    m_hr = 10; m_min = 59; m_sec = 59;
    load_hms();
    cyc(1'b1, 1'b1, 3'd1, 8'h59);
    m_sec = 0; m_min = 59;
    chk_all("R10");
    m_sec = 59;
    load_hms();
    cyc(1'b1, 1'b1, 3'd0, 8'h30);
    m_sec = 30;
    chk_all("R10");
    cyc(1'b0, 1'b1, 3'd7, 8'hFF);
    chk_all("R10");
    cyc(1'b0, 1'b1, 3'd4, 8'h17);
    m_date = 17;
    chk_all("R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule